// File: doc/BRIEF.md
# Low-Power Halt Sequencer

This block moves a small processor between normal execution and two sleep depths. A halt strobe puts the processor to sleep. A control bit chooses the depth. In the deep sleep the main oscillator, the peripheral clock and the CPU clock are all gated off. In the light sleep the oscillator keeps running and the other two clocks are off. On entry to either depth the block forces the two-bit interrupt-mask field to binary 10, so that a wake interrupt can be taken.

A wake-capable interrupt or a reset request ends the sleep. Waking from deep sleep always passes through a stabilization wait before the CPU clock returns. Waking from light sleep skips that wait when an interrupt caused the exit, and applies it when a reset caused the exit. A configuration input sets the wait to 256 or 4096 cycles. It is sampled at the moment of wake-up. A resume output tells the core whether to service the interrupt or to fetch the reset vector. A one-cycle wake-done pulse marks the first cycle in which the CPU clock is enabled again.

Top module: `halt_power_seq`

## Requirements
- R1: In the run state, a halt strobe with `aux_osc_keep`=0 enters deep sleep. From the next cycle on, `osc_en`, `periph_clk_en` and `cpu_clk_en` are all 0.
- R2: In the run state, a halt strobe with `aux_osc_keep`=1 enters light sleep. From the next cycle on, `osc_en`=1 and `periph_clk_en`=`cpu_clk_en`=0.
- R3: `mask_force_vld` is 1 for exactly the first cycle spent in either sleep state, and 0 at all other times. `mask_force_val` always reads 2'b10.
- R4: If a wake interrupt is already high when the halt strobe is taken, the sleep state lasts exactly one cycle before the exit begins.
- R5: Deep sleep stays asleep, with all enables 0, while no wake interrupt and no reset request is present. When it exits, `osc_en` is 1 from the first cycle of the wait onward, and `cpu_clk_en` stays 0 throughout the wait.
- R6: The stabilization wait keeps `cpu_clk_en` at 0 for exactly 256 cycles when `long_wait`=0 and 4096 cycles when `long_wait`=1. The value of `long_wait` is taken in the cycle the wake source is seen. A change of `long_wait` during the wait has no effect.
- R7: Light sleep left by an interrupt re-enables all clocks in the very next cycle, with no wait.
- R8: Light sleep left by a reset request passes through the full stabilization wait.
- R9: `resume_vec` is 0 (service the interrupt) after an interrupt wake and 1 (fetch the reset vector) after a reset wake. After block reset it reads 1.
- R10: A reset request wins over a simultaneous interrupt. A reset request in the run state keeps the block running and sets `resume_vec` to 1.
- R11: A halt strobe is ignored outside the run state. During the wait it neither changes the wait length nor causes a new sleep after wake-up.
- R12: `wake_done` is a single-cycle pulse. It is high in the first cycle in which `cpu_clk_en` is 1 after any sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| halt_req | input | 1 | Halt strobe from the core |
| aux_osc_keep | input | 1 | 1 selects light sleep (oscillator kept on), 0 selects deep sleep |
| wake_irq | input | NUM_IRQ | Wake-capable interrupt requests |
| rst_req | input | 1 | Reset request that wakes the processor |
| long_wait | input | 1 | 1 selects the long stabilization wait, 0 the short one |
| osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| mask_force_vld | output | 1 | Strobe that loads the interrupt-mask field |
| mask_force_val | output | 2 | Value to load into the interrupt-mask field |
| resume_vec | output | 1 | 1 = fetch the reset vector, 0 = service the interrupt |
| wake_done | output | 1 | Pulse in the first cycle the CPU clock runs again |

## Verification
The bench counts the gated cycles of each wait directly. A counter that is off by one, or that reads its length at the wrong time, shows up as 255, 257 or 4096 in place of 256. Light sleep is left once by an interrupt and once by a reset. A design that merged the two exit paths would either delay the interrupt wake or skip the reset wait. A halt strobe that arrives with an interrupt already high must come back out after a single sleep cycle; a design that missed this would stay asleep. A reset that arrives together with an interrupt, and a halt strobe issued during the wait, are also driven. These catch a resume indication with the wrong priority, and a design that falls back to sleep right after waking.

// File: rtl/halt_pkg.sv
package halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DEEP  = 2'd1,
        ST_LIGHT = 2'd2,
        ST_STAB  = 2'd3
    } pwr_state_e;

    typedef enum logic {
        RES_IRQ = 1'b0,
        RES_VEC = 1'b1
    } resume_e;

    typedef struct packed {
        logic osc;
        logic periph;
        logic cpu;
    } clk_en_t;

    localparam logic [1:0] MASK_WAKE_VAL = 2'b10;

    function automatic clk_en_t state_clocks(pwr_state_e s);
        clk_en_t c;
        case (s)
            ST_RUN:   c = '{osc: 1'b1, periph: 1'b1, cpu: 1'b1};
            ST_DEEP:  c = '{osc: 1'b0, periph: 1'b0, cpu: 1'b0};
            ST_LIGHT: c = '{osc: 1'b1, periph: 1'b0, cpu: 1'b0};
            default:  c = '{osc: 1'b1, periph: 1'b0, cpu: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/halt_wake_src.sv
module halt_wake_src #(
    parameter int NUM_IRQ = 4
) (
    input  logic [NUM_IRQ-1:0] irq,
    output logic               any_wake
);
    logic [NUM_IRQ:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_or
        assign chain[g+1] = chain[g] | irq[g];
    end
    assign any_wake = chain[NUM_IRQ];
endmodule

// File: rtl/halt_stab_timer.sv
module halt_stab_timer #(
    parameter int SHORT_WAIT = 256,
    parameter int LONG_WAIT  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_sel,
    output logic expire
);
    localparam int CW = (LONG_WAIT > SHORT_WAIT) ? $clog2(LONG_WAIT) : $clog2(SHORT_WAIT);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_WAIT - 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_WAIT - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;
    logic          busy;

    assign expire = busy && (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            lim_m1 <= SHORT_M1;
            busy   <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            lim_m1 <= long_sel ? LONG_M1 : SHORT_M1;
            busy   <= 1'b1;
        end else if (busy) begin
            if (expire) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= lim_m1)) else $error("count past limit"); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cnt == '0)) else $error("start did not clear"); // R6
endmodule

// File: rtl/halt_clk_decode.sv
module halt_clk_decode
    import halt_pkg::*;
(
    input  pwr_state_e state,
    output logic       osc_en,
    output logic       periph_clk_en,
    output logic       cpu_clk_en
);
    clk_en_t c;

    always_comb begin
        c             = state_clocks(state);
        osc_en        = c.osc;
        periph_clk_en = c.periph;
        cpu_clk_en    = c.cpu;
    end
endmodule

// File: rtl/halt_power_seq.sv
module halt_power_seq
    import halt_pkg::*;
#(
    parameter int NUM_IRQ    = 4,
    parameter int SHORT_WAIT = 256,
    parameter int LONG_WAIT  = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_req,
    input  logic               aux_osc_keep,
    input  logic [NUM_IRQ-1:0] wake_irq,
    input  logic               rst_req,
    input  logic               long_wait,
    output logic               osc_en,
    output logic               periph_clk_en,
    output logic               cpu_clk_en,
    output logic               mask_force_vld,
    output logic [1:0]         mask_force_val,
    output logic               resume_vec,
    output logic               wake_done
);
    pwr_state_e state, nxt;
    resume_e    resume_q, resume_d;
    logic       any_wake;
    logic       tmr_start;
    logic       tmr_expire;
    logic       mask_q;
    logic       wake_q;

    halt_wake_src #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq      (wake_irq),
        .any_wake (any_wake)
    );

    halt_stab_timer #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .start    (tmr_start),
        .long_sel (long_wait),
        .expire   (tmr_expire)
    );

    halt_clk_decode u_dec (
        .state         (state),
        .osc_en        (osc_en),
        .periph_clk_en (periph_clk_en),
        .cpu_clk_en    (cpu_clk_en)
    );

    always_comb begin
        nxt       = state;
        resume_d  = resume_q;
        tmr_start = 1'b0;
        case (state)
            ST_RUN: begin
                if (rst_req) begin
                    resume_d = RES_VEC;
                end else if (halt_req) begin
                    nxt = aux_osc_keep ? ST_LIGHT : ST_DEEP;
                end
            end
            ST_DEEP: begin
                if (rst_req || any_wake) begin
                    nxt       = ST_STAB;
                    tmr_start = 1'b1;
                    resume_d  = rst_req ? RES_VEC : RES_IRQ;
                end
            end
            ST_LIGHT: begin
                if (rst_req) begin
                    nxt       = ST_STAB;
                    tmr_start = 1'b1;
                    resume_d  = RES_VEC;
                end else if (any_wake) begin
                    nxt      = ST_RUN;
                    resume_d = RES_IRQ;
                end
            end
            default: begin
                if (rst_req) begin
                    tmr_start = 1'b1;
                    resume_d  = RES_VEC;
                end else if (tmr_expire) begin
                    nxt = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            resume_q <= RES_VEC;
            mask_q   <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            state    <= nxt;
            resume_q <= resume_d;
            mask_q   <= (state == ST_RUN) && (nxt != ST_RUN);
            wake_q   <= (state != ST_RUN) && (nxt == ST_RUN);
        end
    end

    assign mask_force_vld = mask_q;
    assign mask_force_val = MASK_WAKE_VAL;
    assign resume_vec     = (resume_q == RES_VEC);
    assign wake_done      = wake_q;

    AST_CPU_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (osc_en && periph_clk_en)) else $error("cpu clock without oscillator"); // R1
    AST_MASK_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
        mask_force_vld |-> (!cpu_clk_en && !periph_clk_en)) else $error("mask forced while running"); // R3
    AST_MASK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mask_force_vld |=> !mask_force_vld) else $error("mask strobe too long"); // R3
    AST_LIGHT_IRQ_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LIGHT && !rst_req && any_wake) |=> (cpu_clk_en && resume_vec == 1'b0)) else $error("light wake delayed"); // R7
    AST_WAIT_NO_RESLEEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STAB) |=> (state == ST_STAB || state == ST_RUN)) else $error("sleep from wait"); // R11
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wake_done |=> !wake_done) else $error("wake pulse too long"); // R12
    AST_WAKE_EDGE: assert property (@(posedge clk) disable iff (rst)
        wake_done |-> (cpu_clk_en && !$past(cpu_clk_en))) else $error("wake pulse misplaced"); // R12
endmodule

// File: tb/test_halt_power_seq.sv
module test_halt_power_seq;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          halt_req;
    logic          aux_osc_keep;
    logic [NI-1:0] wake_irq;
    logic          rst_req;
    logic          long_wait;
    logic          osc_en, periph_clk_en, cpu_clk_en;
    logic          mask_force_vld;
    logic [1:0]    mask_force_val;
    logic          resume_vec, wake_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    halt_power_seq #(.NUM_IRQ(NI)) i_halt_power_seq (
        .clk(clk), .rst(rst), .halt_req(halt_req), .aux_osc_keep(aux_osc_keep),
        .wake_irq(wake_irq), .rst_req(rst_req), .long_wait(long_wait),
        .osc_en(osc_en), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
        .mask_force_vld(mask_force_vld), .mask_force_val(mask_force_val),
        .resume_vec(resume_vec), .wake_done(wake_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clks();
        return {29'd0, osc_en, periph_clk_en, cpu_clk_en};
    endfunction

    // Enter sleep: at the first sleep cycle check enables and mask strobe.
    task automatic enter_sleep(input logic light, input logic [NI-1:0] irq_now);
        @(negedge clk);
        halt_req     = 1'b1;
        aux_osc_keep = light;
        wake_irq     = irq_now;
        @(negedge clk);
        halt_req = 1'b0;
        check(light ? "R2 light-sleep enables" : "R1 deep-sleep enables", clks(), light ? 4 : 0);
        check("R3 mask strobe on entry", mask_force_vld, 1);
        check("R3 mask value", mask_force_val, 2);
    endtask

    // Called at the negedge of the first wait cycle; counts gated cycles.
    task automatic count_wait(output int n);
        bool_loop: begin
            n = 0;
            while (!wake_done && n < 6000) begin
                if (cpu_clk_en !== 1'b0 || osc_en !== 1'b1) begin
                    check("R5 wait enables", clks(), 4);
                end
                n++;
                @(negedge clk);
            end
        end
        check("R12 cpu on at wake pulse", cpu_clk_en, 1);
    endtask

    task automatic t_reset();
        check("R9 reset resume value", resume_vec, 1);
        check("R1 run enables", clks(), 7);
        check("R3 no strobe in run", mask_force_vld, 0);
        check("R12 no wake pulse in run", wake_done, 0);
    endtask

    task automatic t_deep_irq_short();
        int n;
        long_wait = 1'b0;
        enter_sleep(1'b0, '0);
        @(negedge clk);
        check("R3 strobe single cycle", mask_force_vld, 0);
        repeat (20) @(negedge clk);
        check("R5 deep sleep holds", clks(), 0);
        wake_irq = 4'b0100;
        @(negedge clk);
        wake_irq = '0;
        long_wait = 1'b1;   // late change must not matter
        count_wait(n);
        check("R6 short wait length", n, 256);
        check("R9 irq resume", resume_vec, 0);
        @(negedge clk);
        check("R12 pulse single cycle", wake_done, 0);
        long_wait = 1'b0;
    endtask

    task automatic t_deep_rst_long();
        int n;
        enter_sleep(1'b0, '0);
        long_wait = 1'b1;
        rst_req   = 1'b1;
        @(negedge clk);
        rst_req   = 1'b0;
        long_wait = 1'b0;
        count_wait(n);
        check("R6 long wait length", n, 4096);
        check("R9 reset resume", resume_vec, 1);
    endtask

    task automatic t_light_irq();
        int n;
        enter_sleep(1'b1, '0);
        repeat (5) @(negedge clk);
        check("R2 light sleep holds", clks(), 4);
        wake_irq = 4'b0001;
        @(negedge clk);
        wake_irq = '0;
        count_wait(n);
        check("R7 no wait on irq from light sleep", n, 0);
        check("R9 irq resume light", resume_vec, 0);
    endtask

    task automatic t_light_rst();
        int n;
        enter_sleep(1'b1, '0);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        count_wait(n);
        check("R8 wait on reset from light sleep", n, 256);
        check("R9 reset resume light", resume_vec, 1);
    endtask

    task automatic t_pending();
        int n;
        enter_sleep(1'b0, 4'b1000);
        @(negedge clk);
        wake_irq = '0;
        check("R4 exit after one sleep cycle", osc_en, 1);
        count_wait(n);
        check("R4 pending wake wait length", n, 256);
        check("R9 pending irq resume", resume_vec, 0);
    endtask

    task automatic t_priority();
        int n;
        enter_sleep(1'b1, '0);
        rst_req  = 1'b1;
        wake_irq = 4'b0010;
        @(negedge clk);
        rst_req  = 1'b0;
        wake_irq = '0;
        count_wait(n);
        check("R10 reset beats irq: wait applied", n, 256);
        check("R10 reset beats irq: resume", resume_vec, 1);
        // irq wake then a reset request in run
        enter_sleep(1'b1, '0);
        wake_irq = 4'b0001;
        @(negedge clk);
        wake_irq = '0;
        check("R9 irq resume before run reset", resume_vec, 0);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        check("R10 run reset sets vector fetch", resume_vec, 1);
        check("R10 run reset keeps running", clks(), 7);
    endtask

    task automatic t_halt_ignored();
        int n;
        enter_sleep(1'b0, '0);
        wake_irq = 4'b0001;
        @(negedge clk);
        wake_irq     = '0;
        halt_req     = 1'b1;
        aux_osc_keep = 1'b1;
        count_wait(n);
        halt_req = 1'b0;
        check("R11 halt during wait: length", n, 256);
        @(negedge clk);
        check("R11 no sleep after wake", clks(), 7);
        check("R11 no mask strobe", mask_force_vld, 0);
    endtask

    initial begin
        halt_req = 1'b0; aux_osc_keep = 1'b0; wake_irq = '0;
        rst_req = 1'b0; long_wait = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_deep_irq_short();
        t_deep_rst_long();
        t_light_irq();
        t_light_rst();
        t_pending();
        t_priority();
        t_halt_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule